// File: doc/BRIEF.md
# Time-of-Day Keeper with Adjustment and Blink Phase

This block keeps the time of day in 24-hour form as three BCD digit pairs: hours, minutes and seconds. A sub-second tick enable arrives from elsewhere on the chip. A parameterised prescaler counts these ticks into whole seconds. Each completed second then ripples through a cascade of seconds, minutes and hours. A separate front-end block classifies button presses and supplies the adjustment pulses and a set-mode flag. Time keeps running in every mode.

While set mode is active, the adjustment pulses add one minute or one hour. A minute bump also zeroes the seconds. The block also produces a visibility signal for the display. In set mode this signal is low during the first half of each second and high during the second half, which gives a 0.5 s off / 0.5 s on blink. Outside set mode it stays high. Seconds are also given in binary for a row of indicator LEDs. Hours and minutes feed an HH:MM digit display.

Top module: `tod_keeper`

## Requirements
- R1: While `lock_n` is low, hours, minutes and seconds read 00:00:00, `seconds_bin` reads 0 and the prescaler phase is cleared.
- R2: Seconds advance by one on the clock edge that accepts the TICKS_PER_SEC-th `tick` pulse of a second. Fewer pulses leave the time unchanged.
- R3: Seconds wrap from 59 to 00 and carry one into the minutes. Minutes wrap from 59 to 00 and carry one into the hours.
- R4: A natural advance from 23:59:59 yields 00:00:00.
- R5: With `set_mode` high, a `bump_min` pulse adds one minute and forces the seconds to 00. A wrap from minute 59 gives 00 and leaves the hours unchanged.
- R6: With `set_mode` high, a `bump_hour` pulse adds one hour and leaves minutes and seconds unchanged. Hour 23 wraps to 00.
- R7: With `set_mode` low, `bump_min` and `bump_hour` have no effect on the time.
- R8: In a cycle with an effective bump, a second that completes in that same cycle is dropped. If both bumps arrive together, both are applied: minutes plus one, hours plus one, seconds 00.
- R9: With `set_mode` high, `show` is low while fewer than TICKS_PER_SEC/2 ticks of the current second have been counted, and high otherwise. With `set_mode` low, `show` is high.
- R10: Time advances in the same way whether `set_mode` is high or low.
- R11: `seconds_bin` equals the binary value of `seconds_bcd`.
- R12: Each output digit pair is legal BCD: the ones digit is at most 9, the minutes and seconds tens digit is at most 5, and the hours value is at most 23. Each byte carries the tens digit in bits [7:4] and the ones digit in bits [3:0].

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; every register uses it |
| lock_n | input | 1 | Active-low clear, held low until the clock is stable |
| tick | input | 1 | Sub-second enable, TICKS_PER_SEC pulses per second |
| set_mode | input | 1 | High while the watch is in time-set mode |
| bump_min | input | 1 | One-cycle pulse: add a minute (set mode only) |
| bump_hour | input | 1 | One-cycle pulse: add an hour (set mode only) |
| hours_bcd | output | 8 | Hours as two BCD digits, 00 to 23 |
| minutes_bcd | output | 8 | Minutes as two BCD digits, 00 to 59 |
| seconds_bcd | output | 8 | Seconds as two BCD digits, 00 to 59 |
| seconds_bin | output | 6 | Seconds in binary for the LED row |
| show | output | 1 | Display visibility (blink in set mode) |

## Verification
The checker watches several rules on every cycle. It confirms that the digits are legal BCD, that the time holds still when no second completes and no bump takes effect, and that a minute bump zeroes the seconds while an hour bump keeps minutes and seconds. It also checks the midnight rollover, that a second colliding with a minute bump is lost, and that `show` stays high outside set mode. Some behaviour can only be shown by the bench's scenarios. These include the exact tick count that makes a second and the half-second placement of the blink. They also include the ignoring of bumps outside set mode and the carry chain over long runs of seconds and bumps.

// File: rtl/tod_pkg.sv
package tod_pkg;

  typedef logic [7:0] bcd2_t;

  // Next BCD value of a two-digit pair, without range wrap.
  function automatic bcd2_t bcd2_next(input bcd2_t v);
    bcd2_t r;
    if (v[3:0] == 4'd9) r = {v[7:4] + 4'd1, 4'd0};
    else                r = {v[7:4], v[3:0] + 4'd1};
    return r;
  endfunction

  // Binary value of a two-digit BCD pair.
  function automatic logic [6:0] bcd2_to_bin(input bcd2_t v);
    return 7'(v[7:4]) * 7'd10 + 7'(v[3:0]);
  endfunction

endpackage

// File: rtl/tod_prescaler.sv
module tod_prescaler #(
  parameter int TICKS_PER_SEC = 1000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  output logic sec_done,
  output logic first_half
);
  localparam int W = (TICKS_PER_SEC > 2) ? $clog2(TICKS_PER_SEC) : 1;
  localparam logic [W-1:0] LAST_C = W'(TICKS_PER_SEC - 1);
  localparam logic [W-1:0] HALF_C = W'(TICKS_PER_SEC / 2);

  logic [W-1:0] phase_q;

  assign sec_done   = tick && (phase_q == LAST_C);
  assign first_half = (phase_q < HALF_C);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        phase_q <= '0;
    else if (sec_done) phase_q <= '0;
    else if (tick)     phase_q <= phase_q + W'(1);
  end
endmodule

// File: rtl/tod_unit.sv
module tod_unit
  import tod_pkg::*;
#(
  parameter int LAST = 59
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  adv,
  input  logic  clr,
  output bcd2_t q,
  output logic  wrap
);
  localparam logic [6:0] LAST_B = 7'(LAST);

  logic at_last;
  assign at_last = (bcd2_to_bin(q) == LAST_B);
  assign wrap    = adv && !clr && at_last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   q <= '0;
    else if (clr) q <= '0;
    else if (adv) q <= at_last ? bcd2_t'(0) : bcd2_next(q);
  end
endmodule

// File: rtl/tod_keeper.sv
module tod_keeper
  import tod_pkg::*;
#(
  parameter int TICKS_PER_SEC = 1000
) (
  input  logic       clk,
  input  logic       lock_n,
  input  logic       tick,
  input  logic       set_mode,
  input  logic       bump_min,
  input  logic       bump_hour,
  output logic [7:0] hours_bcd,
  output logic [7:0] minutes_bcd,
  output logic [7:0] seconds_bcd,
  output logic [5:0] seconds_bin,
  output logic       show
);
  localparam int NUNITS = 3;
  localparam int LASTS [NUNITS] = '{59, 59, 23};

  logic sec_pulse, first_half;
  logic bump_m, bump_h, sec_adv;
  logic [NUNITS-1:0] adv_v, clr_v, wrap_v;
  bcd2_t q_v [NUNITS];

  tod_prescaler #(.TICKS_PER_SEC(TICKS_PER_SEC)) u_pre (
    .clk(clk), .rst_n(lock_n), .tick(tick),
    .sec_done(sec_pulse), .first_half(first_half)
  );

  assign bump_m  = set_mode && bump_min;
  assign bump_h  = set_mode && bump_hour;
  assign sec_adv = sec_pulse && !bump_m && !bump_h;

  // Cascade: 0 = seconds, 1 = minutes, 2 = hours
  assign adv_v[0] = sec_adv;
  assign clr_v[0] = bump_m;
  assign adv_v[1] = wrap_v[0] || bump_m;
  assign clr_v[1] = 1'b0;
  assign adv_v[2] = (wrap_v[1] && !bump_m) || bump_h;
  assign clr_v[2] = 1'b0;

  for (genvar i = 0; i < NUNITS; i++) begin : g_unit
    tod_unit #(.LAST(LASTS[i])) u_unit (
      .clk(clk), .rst_n(lock_n), .adv(adv_v[i]), .clr(clr_v[i]),
      .q(q_v[i]), .wrap(wrap_v[i])
    );
  end

  assign seconds_bcd = q_v[0];
  assign minutes_bcd = q_v[1];
  assign hours_bcd   = q_v[2];
  assign seconds_bin = 6'(bcd2_to_bin(q_v[0]));
  assign show        = !(set_mode && first_half);
endmodule

// File: rtl/tod_keeper_chk.sv
module tod_keeper_chk (
  input logic       clk,
  input logic       lock_n,
  input logic       set_mode,
  input logic       sec_pulse,
  input logic       bump_m,
  input logic       bump_h,
  input logic [7:0] hours_bcd,
  input logic [7:0] minutes_bcd,
  input logic [7:0] seconds_bcd,
  input logic       show
);
  a_r12_digits_legal: assert property (@(posedge clk) disable iff (!lock_n)
    seconds_bcd[3:0] <= 4'd9 && seconds_bcd[7:4] <= 4'd5 &&
    minutes_bcd[3:0] <= 4'd9 && minutes_bcd[7:4] <= 4'd5 &&
    hours_bcd[3:0] <= 4'd9 && hours_bcd <= 8'h23);

  a_r2_hold_when_idle: assert property (@(posedge clk) disable iff (!lock_n)
    (!sec_pulse && !bump_m && !bump_h) |=>
      ($stable(seconds_bcd) && $stable(minutes_bcd) && $stable(hours_bcd)));

  a_r5_min_bump_clears_sec: assert property (@(posedge clk) disable iff (!lock_n)
    (bump_m && !bump_h) |=> (seconds_bcd == 8'h00 && $stable(hours_bcd)));

  a_r6_hour_bump_keeps_ms: assert property (@(posedge clk) disable iff (!lock_n)
    (bump_h && !bump_m) |=> ($stable(minutes_bcd) && $stable(seconds_bcd)));

  a_r4_midnight: assert property (@(posedge clk) disable iff (!lock_n)
    (sec_pulse && !bump_m && !bump_h && hours_bcd == 8'h23 &&
     minutes_bcd == 8'h59 && seconds_bcd == 8'h59) |=>
      (hours_bcd == 8'h00 && minutes_bcd == 8'h00 && seconds_bcd == 8'h00));

  a_r8_collision_drop: assert property (@(posedge clk) disable iff (!lock_n)
    (sec_pulse && bump_m) |=> (seconds_bcd == 8'h00));

  a_r9_show_outside_set: assert property (@(posedge clk) disable iff (!lock_n)
    !set_mode |-> show);
endmodule

bind tod_keeper tod_keeper_chk u_chk (
  .clk(clk), .lock_n(lock_n), .set_mode(set_mode),
  .sec_pulse(sec_pulse), .bump_m(bump_m), .bump_h(bump_h),
  .hours_bcd(hours_bcd), .minutes_bcd(minutes_bcd),
  .seconds_bcd(seconds_bcd), .show(show)
);

// File: tb/tod_keeper_test.sv
`timescale 1ns/1ps
module tod_keeper_test;
  localparam int TPS = 4;

  logic clk = 1'b0, lock_n = 1'b0, tick = 1'b0, set_mode = 1'b0;
  logic bump_min = 1'b0, bump_hour = 1'b0;
  logic [7:0] hours_bcd, minutes_bcd, seconds_bcd;
  logic [5:0] seconds_bin;
  logic show;
  int checks = 0, failures = 0;

  always #2 clk = ~clk;

  tod_keeper #(.TICKS_PER_SEC(TPS)) uut (
    .clk(clk), .lock_n(lock_n), .tick(tick), .set_mode(set_mode),
    .bump_min(bump_min), .bump_hour(bump_hour),
    .hours_bcd(hours_bcd), .minutes_bcd(minutes_bcd),
    .seconds_bcd(seconds_bcd), .seconds_bin(seconds_bin), .show(show)
  );

  // Table entries: {action, expected HH MM SS in BCD}; action 0 second, 1 minute, 2 hour
  localparam logic [25:0] STEPS [8] = '{
    {2'd2, 24'h010000}, {2'd1, 24'h010100}, {2'd0, 24'h010101},
    {2'd0, 24'h010102}, {2'd1, 24'h010200}, {2'd2, 24'h020200},
    {2'd0, 24'h020201}, {2'd2, 24'h030201}};

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic chk_time(input string tag, input logic [23:0] exp);
    chk(tag, {hours_bcd, minutes_bcd, seconds_bcd}, exp);
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) tick = 1'b1;
      @(negedge clk) tick = 1'b0;
    end
  endtask

  task automatic seconds(input int n);
    ticks(n * TPS);
  endtask

  task automatic bump(input bit m, input bit h, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) begin bump_min = m; bump_hour = h; end
      @(negedge clk) begin bump_min = 1'b0; bump_hour = 1'b0; end
    end
  endtask

  task automatic do_reset();
    @(negedge clk) lock_n = 1'b0;
    repeat (3) @(negedge clk);
    lock_n = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    #(4 * 200000);
    failures++;
    checks++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    // R1 reset state
    repeat (3) @(negedge clk);
    chk_time("R1 time during reset", 24'h000000);
    chk("R1 seconds_bin during reset", seconds_bin, 0);
    lock_n = 1'b1;
    @(negedge clk);

    // Table walk in set mode: R5, R6, R10
    set_mode = 1'b1;
    foreach (STEPS[k]) begin
      case (STEPS[k][25:24])
        2'd0: seconds(1);
        2'd1: bump(1, 0, 1);
        default: bump(0, 1, 1);
      endcase
      chk_time("R5 R6 R10 table step", STEPS[k][23:0]);
    end

    // R2 tick count, R9 steady show, R7 ignored bumps
    set_mode = 1'b0;
    do_reset();
    ticks(TPS - 1);
    chk_time("R2 short of a second", 24'h000000);
    chk("R9 show outside set mode", show, 1);
    ticks(1);
    chk_time("R2 full second", 24'h000001);
    bump(1, 0, 1);
    bump(0, 1, 1);
    bump(1, 1, 1);
    chk_time("R7 bumps ignored outside set mode", 24'h000001);

    // R9 blink phase
    set_mode = 1'b1;
    @(negedge clk);
    chk("R9 first half blank", show, 0);
    ticks(TPS / 2);
    chk("R9 second half shown", show, 1);
    ticks(TPS / 2);
    chk("R9 new second blank", show, 0);
    chk_time("R10 advance in set mode", 24'h000002);

    // R3 carry, R11 binary seconds
    set_mode = 1'b0;
    seconds(57);
    chk_time("R3 reached 59 s", 24'h000059);
    chk("R11 seconds_bin at 59", seconds_bin, 59);
    seconds(1);
    chk_time("R3 seconds carry", 24'h000100);

    // R5 minute wrap without hour carry, R12 digit form
    set_mode = 1'b1;
    bump(1, 0, 58);
    chk("R12 minutes digits at 59", minutes_bcd, 8'h59);
    bump(1, 0, 1);
    chk_time("R5 minute wrap no carry", 24'h000000);

    // R6 hour wrap
    bump(0, 1, 23);
    chk("R6 hour 23", hours_bcd, 8'h23);
    bump(0, 1, 1);
    chk_time("R6 hour wrap", 24'h000000);

    // R4 midnight, R3 minute carry into hours
    bump(0, 1, 23);
    bump(1, 0, 59);
    seconds(59);
    chk_time("R3 at 23:59:59", 24'h235959);
    seconds(1);
    chk_time("R4 midnight rollover", 24'h000000);

    // R8 collision and double bump
    ticks(TPS - 1);
    @(negedge clk) begin tick = 1'b1; bump_min = 1'b1; end
    @(negedge clk) begin tick = 1'b0; bump_min = 1'b0; end
    chk_time("R8 second dropped on bump", 24'h000100);
    seconds(1);
    chk_time("R8 next second normal", 24'h000101);
    bump(1, 1, 1);
    chk_time("R8 both bumps applied", 24'h010200);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule